// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small, fully associative store that sits beside a direct-mapped cache and holds the lines that cache has recently thrown out. Every line the main cache displaces is handed to the buffer together with its block address, which is the main-cache tag joined to the set index. The buffer compares that address against every entry at once. It keeps the line so that a later conflict miss on the same block can be served without a trip to the next level.

The main cache raises a lookup only when its own tag check fails. The buffer compares the requested block address against all entries in parallel and answers one cycle later. On a hit it returns the stored line through the swap-out data port and gives up the entry. If the main cache evicts a line in the same cycle, for example the line that the returning block displaces, that line takes the freed slot, so the two lines trade places. On a miss the response says so and passes the block address on as a request for the lower level. When the buffer is full, a new line displaces the entry that was inserted longest ago. Empty slots are always used first.

Top module: `victim_buf`

## Requirements
- R1: Reset, which is synchronous and active low, empties every entry. Neither response strobe is high while reset is held, and any lookup after reset misses until a line has been inserted.
- R2: A lookup with `lkp_valid` high in cycle n gets its response in cycle n+1. At that point `rsp_valid` is high and exactly one of `rsp_hit` and `fwd_valid` is high. Without a lookup, `rsp_valid` is low one cycle later.
- R3: A line inserted through the evict port can be retrieved by a later lookup of the same block address. The lookup returns the inserted data on `rsp_line` with `rsp_hit` high.
- R4: A lookup that matches no entry raises `fwd_valid` and presents the looked-up block address on `fwd_blk`.
- R5: A lookup that hits with no eviction in the same cycle removes the hit entry. A second lookup of that address misses, and occupancy drops by one.
- R6: A lookup hit accompanied by an eviction of an address not already held returns the hit line and stores the evicted line in its place. Occupancy is unchanged, and the evicted line becomes the most recently inserted entry.
- R7: An insertion while any slot is empty fills an empty slot and displaces no stored line.
- R8: An insertion into a full buffer replaces the entry inserted longest ago, so entries leave in insertion order.
- R9: No block address is held twice. Evicting an address already present rewrites that entry's data in place and marks it the most recently inserted, so at most one entry can match a lookup.
- R10: A lookup sees the contents as they were before any insertion made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| evict_valid | input | 1 | A line displaced from the main cache is offered this cycle |
| evict_blk | input | TAG_W+IDX_W | Block address (tag then index) of the displaced line |
| evict_line | input | LINE_W | Data of the displaced line |
| lkp_valid | input | 1 | Main cache missed; search the buffer |
| lkp_blk | input | TAG_W+IDX_W | Block address to search for |
| rsp_valid | output | 1 | Response to the lookup of the previous cycle |
| rsp_hit | output | 1 | The previous lookup hit |
| rsp_line | output | LINE_W | Swap-out data: the line returned on a hit, zero on a miss |
| fwd_valid | output | 1 | The previous lookup missed; request for the lower level |
| fwd_blk | output | TAG_W+IDX_W | Block address forwarded to the lower level |

## Verification
Some properties hold in every cycle, and the embedded assertions check those. Each response is either a hit or a forward, never both. At most one entry matches any address. Occupancy falls by exactly one after a plain hit and stays the same across a swap. A full buffer always has exactly one oldest entry and comes up empty from reset. Which stored data comes back, and which entry a full buffer gives up, depend on the history of insertions. Only the bench's scenarios can show these: eviction order after refills and swaps, refreshing of a duplicate address, and same-cycle lookup against insertion.

// File: rtl/vc_pkg.sv
// Package: shared types for the victim line buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package vc_pkg;

    // How an evicted line enters the buffer in a given cycle.
    typedef enum logic [2:0] {
        INS_NONE    = 3'd0,  // no eviction this cycle
        INS_UPDATE  = 3'd1,  // address already held: rewrite in place
        INS_SWAP    = 3'd2,  // take the slot freed by a lookup hit
        INS_FILL    = 3'd3,  // take an empty slot
        INS_REPLACE = 3'd4   // displace the oldest entry
    } ins_kind_e;

endpackage

// File: rtl/vc_entry.sv
// Module: vc_entry
// One slot of the buffer: a valid bit, a block address, a line of data,
// and two comparators (one for lookups, one for evictions).
// Assumes: wr_en and inv_en never both select a slot that must stay valid;
// a write takes priority over an invalidate.
module vc_entry #(
    parameter int BLK_W  = 12,
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BLK_W-1:0]  wr_blk,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              inv_en,
    input  logic [BLK_W-1:0]  lkp_blk,
    output logic              valid_o,
    output logic [LINE_W-1:0] line_o,
    output logic              lkp_hit_o,
    output logic              ev_hit_o
);

    logic              valid_q;
    logic [BLK_W-1:0]  blk_q;
    logic [LINE_W-1:0] line_q;

    // Valid flag: cleared by reset or invalidate, set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)      valid_q <= 1'b0;
        else if (wr_en)  valid_q <= 1'b1;
        else if (inv_en) valid_q <= 1'b0;
    end

    // Address and data payload: loaded on a write only.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            blk_q  <= wr_blk;
            line_q <= wr_line;
        end
    end

    // Per-slot comparators against the lookup and the evicted address.
    always_comb begin
        lkp_hit_o = valid_q && (blk_q == lkp_blk);
        ev_hit_o  = valid_q && (blk_q == wr_blk);
    end

    assign valid_o = valid_q;
    assign line_o  = line_q;

endmodule

// File: rtl/vc_order.sv
// Module: vc_order
// Chooses the slot an evicted line goes to and which slot a lookup hit
// frees, and tracks insertion age per slot (0 = newest). Valid slots
// always carry distinct ages 0..count-1.
// Assumes: valid_i mirrors the slot valid bits, which follow wr_vec/inv_vec.
module vc_order
    import vc_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic               lkp_req,
    input  logic [ENTRIES-1:0] lkp_hit_vec,
    input  logic               ev_req,
    input  logic [ENTRIES-1:0] ev_hit_vec,
    output logic [ENTRIES-1:0] wr_vec,
    output logic [ENTRIES-1:0] inv_vec
);

    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int AW = IW;

    logic [AW-1:0]      age_q   [ENTRIES];
    logic [AW-1:0]      age_nx  [ENTRIES];
    logic [ENTRIES-1:0] old_vec;
    logic [IW-1:0]      hit_idx, dup_idx, free_idx, old_idx, tgt_idx;
    logic               lkp_any, ev_dup, free_any, rm_en;
    ins_kind_e          kind;

    // Encoders for hit, duplicate, first empty and oldest slot.
    always_comb begin
        hit_idx  = '0;
        dup_idx  = '0;
        free_idx = '0;
        old_idx  = '0;
        old_vec  = '0;
        for (int j = ENTRIES - 1; j >= 0; j--) begin
            if (lkp_hit_vec[j]) hit_idx  = IW'(j);
            if (ev_hit_vec[j])  dup_idx  = IW'(j);
            if (!valid_i[j])    free_idx = IW'(j);
            if (valid_i[j] && (int'(age_q[j]) == ENTRIES - 1)) begin
                old_idx    = IW'(j);
                old_vec[j] = 1'b1;
            end
        end
    end

    // Insertion kind and target slot, in priority order.
    always_comb begin
        lkp_any  = lkp_req && (|lkp_hit_vec);
        ev_dup   = ev_req && (|ev_hit_vec);
        free_any = ~&valid_i;
        if (!ev_req)       begin kind = INS_NONE;    tgt_idx = '0;       end
        else if (ev_dup)   begin kind = INS_UPDATE;  tgt_idx = dup_idx;  end
        else if (lkp_any)  begin kind = INS_SWAP;    tgt_idx = hit_idx;  end
        else if (free_any) begin kind = INS_FILL;    tgt_idx = free_idx; end
        else               begin kind = INS_REPLACE; tgt_idx = old_idx;  end
        rm_en   = lkp_any && (kind != INS_SWAP) &&
                  !((kind == INS_UPDATE) && (dup_idx == hit_idx));
        wr_vec  = (kind != INS_NONE) ? (ENTRIES'(1) << tgt_idx) : '0;
        inv_vec = rm_en ? (ENTRIES'(1) << hit_idx) : '0;
    end

    // Next ages: first close the gap of a removed slot, then age the rest
    // around the newly written slot.
    always_comb begin
        logic [ENTRIES-1:0] v1;
        int                 thr;
        v1 = valid_i;
        for (int j = 0; j < ENTRIES; j++) age_nx[j] = age_q[j];
        if (rm_en) begin
            for (int j = 0; j < ENTRIES; j++)
                if (valid_i[j] && (age_q[j] > age_q[hit_idx]))
                    age_nx[j] = age_q[j] - 1'b1;
            v1[hit_idx] = 1'b0;
        end
        thr = v1[tgt_idx] ? int'(age_nx[tgt_idx]) : ENTRIES;
        if (kind != INS_NONE) begin
            for (int j = 0; j < ENTRIES; j++)
                if ((IW'(j) != tgt_idx) && v1[j] && (int'(age_nx[j]) < thr))
                    age_nx[j] = age_nx[j] + 1'b1;
            age_nx[tgt_idx] = '0;
        end
    end

    // Age registers.
    always_ff @(posedge clk) begin
        for (int j = 0; j < ENTRIES; j++)
            age_q[j] <= rst_n ? age_nx[j] : '0;
    end

    // R8: a full buffer has exactly one oldest entry to give up.
    p_single_oldest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_i) |-> ($countones(old_vec) == 1))
        else $error("full buffer without a unique oldest entry");

endmodule

// File: rtl/vc_resp.sv
// Module: vc_resp
// Registers the lookup result: hit with its line, or miss with the
// block address forwarded to the lower level.
// Assumes: at most one slot matches, so the line input is already selected.
module vc_resp #(
    parameter int BLK_W  = 12,
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lkp_req,
    input  logic [BLK_W-1:0]  lkp_blk,
    input  logic              hit,
    input  logic [LINE_W-1:0] hit_line,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [LINE_W-1:0] rsp_line,
    output logic              fwd_valid,
    output logic [BLK_W-1:0]  fwd_blk
);

    // Response strobes: cleared on reset, else follow this cycle's lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            fwd_valid <= 1'b0;
        end else begin
            rsp_valid <= lkp_req;
            rsp_hit   <= lkp_req && hit;
            fwd_valid <= lkp_req && !hit;
        end
    end

    // Response payload: returned line on a hit, forwarded address always.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_line <= '0;
            fwd_blk  <= '0;
        end else if (lkp_req) begin
            rsp_line <= hit ? hit_line : '0;
            fwd_blk  <= lkp_blk;
        end
    end

    // R2: every response is either a hit or a forward, never both.
    p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ^ fwd_valid))
        else $error("response is neither or both of hit and forward");

    // R4: a forward never appears without a response.
    p_fwd_in_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> rsp_valid)
        else $error("forward without response");

endmodule

// File: rtl/victim_buf.sv
// Module: victim_buf (top)
// Fully associative store of lines evicted from a direct-mapped cache.
// Searched on main-cache misses; a hit returns and frees the entry, and a
// same-cycle eviction takes that slot. Misses are forwarded downward.
// Assumes: the block address is {tag, index}; ENTRIES >= 2.
module victim_buf #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 8,
    parameter int IDX_W   = 4,
    parameter int LINE_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   evict_valid,
    input  logic [TAG_W+IDX_W-1:0] evict_blk,
    input  logic [LINE_W-1:0]      evict_line,
    input  logic                   lkp_valid,
    input  logic [TAG_W+IDX_W-1:0] lkp_blk,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic [LINE_W-1:0]      rsp_line,
    output logic                   fwd_valid,
    output logic [TAG_W+IDX_W-1:0] fwd_blk
);

    localparam int BLK_W = TAG_W + IDX_W;

    logic [ENTRIES-1:0] valid_vec, lkp_hit_vec, ev_hit_vec, wr_vec, inv_vec;
    logic [LINE_W-1:0]  slot_line [ENTRIES];
    logic [LINE_W-1:0]  sel_line;

    // One slot per entry, each with its own comparators.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        vc_entry #(.BLK_W(BLK_W), .LINE_W(LINE_W)) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_vec[g]),
            .wr_blk    (evict_blk),
            .wr_line   (evict_line),
            .inv_en    (inv_vec[g]),
            .lkp_blk   (lkp_blk),
            .valid_o   (valid_vec[g]),
            .line_o    (slot_line[g]),
            .lkp_hit_o (lkp_hit_vec[g]),
            .ev_hit_o  (ev_hit_vec[g])
        );
    end

    // Placement and insertion-order tracking.
    vc_order #(.ENTRIES(ENTRIES)) u_order (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (valid_vec),
        .lkp_req     (lkp_valid),
        .lkp_hit_vec (lkp_hit_vec),
        .ev_req      (evict_valid),
        .ev_hit_vec  (ev_hit_vec),
        .wr_vec      (wr_vec),
        .inv_vec     (inv_vec)
    );

    // AND-OR select of the matching slot's line.
    always_comb begin
        sel_line = '0;
        for (int j = 0; j < ENTRIES; j++)
            if (lkp_hit_vec[j]) sel_line = sel_line | slot_line[j];
    end

    // Registered lookup response.
    vc_resp #(.BLK_W(BLK_W), .LINE_W(LINE_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .lkp_req   (lkp_valid),
        .lkp_blk   (lkp_blk),
        .hit       (|lkp_hit_vec),
        .hit_line  (sel_line),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_line  (rsp_line),
        .fwd_valid (fwd_valid),
        .fwd_blk   (fwd_blk)
    );

    // R9: no address is ever held in two slots.
    p_no_dup_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lkp_hit_vec) && $onehot0(ev_hit_vec))
        else $error("block address matched in more than one slot");

    // R1: the buffer leaves reset empty.
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_vec == '0))
        else $error("entry valid right after reset");

    // R5: a plain hit frees exactly one slot.
    p_hit_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && (|lkp_hit_vec) && !evict_valid) |=>
        ($countones(valid_vec) == $countones($past(valid_vec)) - 1))
        else $error("plain hit did not free one slot");

    // R6: a swap keeps occupancy unchanged.
    p_swap_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && (|lkp_hit_vec) && evict_valid && !(|ev_hit_vec)) |=>
        ($countones(valid_vec) == $countones($past(valid_vec))))
        else $error("swap changed occupancy");

endmodule

// File: tb/tb_victim_buf.sv
// Bench for victim_buf: a vector table walked by one loop, then directed
// tests for duplicate insertion, refresh order, same-cycle lookup and reset.
module tb_victim_buf;

    localparam int CLK_PERIOD = 10;
    localparam int BW = 12;
    localparam int LW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evict_valid = 1'b0;
    logic [BW-1:0] evict_blk = '0;
    logic [LW-1:0] evict_line = '0;
    logic          lkp_valid = 1'b0;
    logic [BW-1:0] lkp_blk = '0;
    logic          rsp_valid, rsp_hit, fwd_valid;
    logic [LW-1:0] rsp_line;
    logic [BW-1:0] fwd_blk;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    victim_buf dut (
        .clk(clk), .rst_n(rst_n),
        .evict_valid(evict_valid), .evict_blk(evict_blk), .evict_line(evict_line),
        .lkp_valid(lkp_valid), .lkp_blk(lkp_blk),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_line(rsp_line),
        .fwd_valid(fwd_valid), .fwd_blk(fwd_blk)
    );

    typedef struct packed {
        logic [3:0]    req;
        logic          ev_v;
        logic [BW-1:0] ev_blk;
        logic [LW-1:0] ev_line;
        logic          lk_v;
        logic [BW-1:0] lk_blk;
        logic          ex_hit;
        logic [LW-1:0] ex_line;
    } vec_t;

    // Buffer holds 4 entries. Comments give the contents, oldest first.
    localparam vec_t VEC [17] = '{
        '{4'd1, 1'b0, 12'h000, 32'h0,         1'b1, 12'h001, 1'b0, 32'h0},          // R1 empty -> miss
        '{4'd7, 1'b1, 12'h011, 32'hA0A0_0011, 1'b0, 12'h000, 1'b0, 32'h0},          // R7 A
        '{4'd7, 1'b1, 12'h022, 32'hA0A0_0022, 1'b0, 12'h000, 1'b0, 32'h0},          // R7 A B
        '{4'd7, 1'b1, 12'h033, 32'hA0A0_0033, 1'b0, 12'h000, 1'b0, 32'h0},          // R7 A B C
        '{4'd7, 1'b1, 12'h044, 32'hA0A0_0044, 1'b0, 12'h000, 1'b0, 32'h0},          // R7 A B C D
        '{4'd8, 1'b1, 12'h055, 32'hA0A0_0055, 1'b0, 12'h000, 1'b0, 32'h0},          // R8 B C D E
        '{4'd8, 1'b0, 12'h000, 32'h0,         1'b1, 12'h011, 1'b0, 32'h0},          // R8 A gone
        '{4'd3, 1'b0, 12'h000, 32'h0,         1'b1, 12'h022, 1'b1, 32'hA0A0_0022},  // R3 B hit -> C D E
        '{4'd7, 1'b1, 12'h066, 32'hA0A0_0066, 1'b0, 12'h000, 1'b0, 32'h0},          // R7 C D E F
        '{4'd6, 1'b1, 12'h077, 32'hA0A0_0077, 1'b1, 12'h033, 1'b1, 32'hA0A0_0033},  // R6 swap -> D E F G
        '{4'd8, 1'b1, 12'h088, 32'hA0A0_0088, 1'b0, 12'h000, 1'b0, 32'h0},          // R8 E F G H
        '{4'd8, 1'b0, 12'h000, 32'h0,         1'b1, 12'h044, 1'b0, 32'h0},          // R8 D gone
        '{4'd6, 1'b0, 12'h000, 32'h0,         1'b1, 12'h077, 1'b1, 32'hA0A0_0077},  // R6 G stored
        '{4'd3, 1'b0, 12'h000, 32'h0,         1'b1, 12'h055, 1'b1, 32'hA0A0_0055},  // R3
        '{4'd3, 1'b0, 12'h000, 32'h0,         1'b1, 12'h066, 1'b1, 32'hA0A0_0066},  // R3
        '{4'd3, 1'b0, 12'h000, 32'h0,         1'b1, 12'h088, 1'b1, 32'hA0A0_0088},  // R3
        '{4'd5, 1'b0, 12'h000, 32'h0,         1'b1, 12'h055, 1'b0, 32'h0}           // R5 E removed
    };

    task automatic chk(input bit ok, input int req, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then check the response at the
    // next falling edge (one register between lookup and response).
    task automatic step(input int req, input bit ev_v, input logic [BW-1:0] eb,
                        input logic [LW-1:0] el, input bit lk_v,
                        input logic [BW-1:0] lb, input bit ex_hit,
                        input logic [LW-1:0] ex_line);
        evict_valid = ev_v; evict_blk = eb; evict_line = el;
        lkp_valid = lk_v; lkp_blk = lb;
        @(negedge clk);
        evict_valid = 1'b0; lkp_valid = 1'b0;
        if (!lk_v) begin
            chk(rsp_valid == 1'b0, 2, 64'(rsp_valid), 64'd0, "idle rsp_valid"); // R2
        end else begin
            chk(rsp_valid == 1'b1, 2, 64'(rsp_valid), 64'd1, "rsp_valid");      // R2
            chk(rsp_hit == ex_hit, req, 64'(rsp_hit), 64'(ex_hit), "rsp_hit");
            if (ex_hit)
                chk(rsp_line == ex_line, req, 64'(rsp_line), 64'(ex_line), "rsp_line");
            else begin
                chk(fwd_valid == 1'b1, 4, 64'(fwd_valid), 64'd1, "fwd_valid");  // R4
                chk(fwd_blk == lb, 4, 64'(fwd_blk), 64'(lb), "fwd_blk");        // R4
            end
        end
    endtask

    initial begin
        // R1: strobes stay low while reset is held.
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0 && fwd_valid == 1'b0, 1,
            64'({rsp_valid, fwd_valid}), 64'd0, "strobes in reset");
        rst_n = 1'b1;

        for (int i = 0; i < 17; i++)
            step(int'(VEC[i].req), VEC[i].ev_v, VEC[i].ev_blk, VEC[i].ev_line,
                 VEC[i].lk_v, VEC[i].lk_blk, VEC[i].ex_hit, VEC[i].ex_line);

        // R9: evicting a held address rewrites it; only one copy exists.
        step(9, 1, 12'h0A1, 32'h1111_0001, 0, '0, 0, '0);
        step(9, 1, 12'h0A1, 32'h1111_0002, 0, '0, 0, '0);
        step(9, 0, '0, '0, 1, 12'h0A1, 1, 32'h1111_0002);
        step(9, 0, '0, '0, 1, 12'h0A1, 0, '0);

        // R9: a rewrite counts as the newest insertion for replacement order.
        step(9, 1, 12'h0B1, 32'h2222_0001, 0, '0, 0, '0);
        step(9, 1, 12'h0B2, 32'h2222_0002, 0, '0, 0, '0);
        step(9, 1, 12'h0B3, 32'h2222_0003, 0, '0, 0, '0);
        step(9, 1, 12'h0B4, 32'h2222_0004, 0, '0, 0, '0);
        step(9, 1, 12'h0B1, 32'h2222_0011, 0, '0, 0, '0);
        step(8, 1, 12'h0B5, 32'h2222_0005, 0, '0, 0, '0);
        step(8, 0, '0, '0, 1, 12'h0B2, 0, '0);
        step(9, 0, '0, '0, 1, 12'h0B1, 1, 32'h2222_0011);

        // R10: a lookup in the inserting cycle sees the old contents.
        step(10, 1, 12'h0C1, 32'h3333_0001, 1, 12'h0C1, 0, '0);
        step(10, 0, '0, '0, 1, 12'h0C1, 1, 32'h3333_0001);

        // R1: reset mid-run empties held lines (0B3 is still stored here).
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step(1, 0, '0, '0, 1, 12'h0B3, 0, '0);
        step(1, 0, '0, '0, 1, 12'h0B4, 0, '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule